// File: doc/BRIEF.md
# Key Wake-Up Port with Edge Interrupts

This block is a general-purpose I/O port of configurable width in which every pin can record a wake-up event on a programmable edge. Each pin has a direction bit, a polarity bit and an interrupt-enable bit. The polarity bit selects the trigger edge and the kind of pull resistor on an input pin. A sticky flag per pin captures the chosen edge. Edges are seen whether the pin is an input or an output, because detection always looks at the pad's input path.

Pad inputs are brought into the system clock domain through a flop synchronizer. The last synchronized value is kept and compared with the current one to find edges. Software reaches the registers through a single-cycle register bus. The bus has no back-pressure: a write selected on a clock edge takes effect on that edge, and read data is a combinational function of the address while the bus is selected. The port drives per-pin output-enable, output-value, pull-enable and pull-direction controls to the pads. It raises a level interrupt from enabled flags and a one-cycle wake pulse when an enabled edge is seen.

Register addresses (3-bit): 0 port data (write sets the output latch, read returns the synchronized pin levels), 1 direction, 2 polarity, 3 interrupt enable, 4 flags (write 1 to clear), 5 control (bit 0 = port pull enable).

Top module: `kwu_port`

## Requirements
- R1: After reset, the direction, polarity, interrupt-enable, flag and control registers all read 0. pad_oe, pad_pull_en, irq and wake are 0, and pad_pull_up is all ones.
- R2: A direction bit of 1 sets that pin's pad_oe bit. pad_out always carries the value last written to address 0.
- R3: With polarity bit 0, a falling edge on the synchronized pin sets that pin's flag. A rising edge does not.
- R4: With polarity bit 1, a rising edge sets that pin's flag. A falling edge does not.
- R5: Edges set flags on pins whose direction bit is 1 (outputs) exactly as on input pins.
- R6: A flag stays set until a 1 is written to its bit at address 4. Writing 0 leaves it. If an edge and a clear land on the same clock edge, the flag ends up set.
- R7: irq is 1 exactly when some pin has both its flag and its enable bit set. A flag on a disabled pin does not raise irq.
- R8: pad_pull_en for a pin is 1 only when the control pull bit is 1 and the pin is an input. pad_pull_up is the inverse of the polarity bit (polarity 0 pulls up, polarity 1 pulls down).
- R9: wake is high for exactly one cycle when an enabled pin sees its selected edge. It is high in the cycle before the flag becomes visible.
- R10: A pad change applied after clock edge k is detected (wake) after edge k+2. Its flag and irq appear after edge k+3.
- R11: A read of address 0 returns the synchronized pin levels, not the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data (0 when not selected) |
| pad_in | input | W | Pin levels from the pads |
| pad_out | output | W | Output latch to the pads |
| pad_oe | output | W | Per-pin output enable |
| pad_pull_en | output | W | Per-pin pull resistor enable |
| pad_pull_up | output | W | Per-pin pull direction, 1 = up, 0 = down |
| irq | output | 1 | Level interrupt from enabled flags |
| wake | output | 1 | One-cycle pulse on an enabled edge |

## Verification
The bench builds the port at its default width of eight pins with a two-stage synchronizer. This lets one pin vector hold both polarity settings at once, with rising-trigger pins in the low nibble and falling-trigger pins in the high nibble. Output and input pins sit side by side, so the effects of a single pad change on the flags can be checked across all pins in one read. With two synchronizer stages the detection and flag latencies are fixed at two and three edges. The bench uses that to hit the cycle where a flag clear and a new edge coincide.

// File: rtl/kwu_pkg.sv
package kwu_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_POL  = 3'd2,
    REG_IEN  = 3'd3,
    REG_FLAG = 3'd4,
    REG_CTRL = 3'd5
  } kwu_reg_e;
endpackage

// File: rtl/kwu_sync.sv
module kwu_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/kwu_edge.sv
module kwu_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] prev,
  output logic [W-1:0] evt,
  output logic [W-1:0] flags
);
  logic [W-1:0] rise, fall;

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
  assign evt  = (rise & pol) | (fall & ~pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      flags <= '0;
    end else begin
      prev  <= cur;
      flags <= (flags & ~clr) | evt;
    end
  end
endmodule

// File: rtl/kwu_regs.sv
module kwu_regs
  import kwu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_sync,
  input  logic [W-1:0]      flags,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      ien,
  output logic              pull_on,
  output logic [W-1:0]      clr
);
  logic wr;
  assign wr = bus_sel && bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dir     <= '0;
      pol     <= '0;
      ien     <= '0;
      pull_on <= 1'b0;
    end else if (wr) begin
      case (bus_addr)
        REG_DATA: dout    <= bus_wdata;
        REG_DIR:  dir     <= bus_wdata;
        REG_POL:  pol     <= bus_wdata;
        REG_IEN:  ien     <= bus_wdata;
        REG_CTRL: pull_on <= bus_wdata[0];
        default:  ;
      endcase
    end
  end

  assign clr = (wr && bus_addr == REG_FLAG) ? bus_wdata : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        REG_DATA: bus_rdata = pin_sync;
        REG_DIR:  bus_rdata = dir;
        REG_POL:  bus_rdata = pol;
        REG_IEN:  bus_rdata = ien;
        REG_FLAG: bus_rdata = flags;
        REG_CTRL: bus_rdata = {{(W-1){1'b0}}, pull_on};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kwu_port.sv
module kwu_port
  import kwu_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pull_en,
  output logic [W-1:0]      pad_pull_up,
  output logic              irq,
  output logic              wake
);
  logic [W-1:0] sync_q, prev_q, evt, flag_q;
  logic [W-1:0] dout, dir_q, pol_q, ien_q, clr;
  logic         pull_on;

  kwu_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
  );

  kwu_edge #(.W(W)) u_edge (
    .clk(clk), .rst(rst), .cur(sync_q), .pol(pol_q), .clr(clr),
    .prev(prev_q), .evt(evt), .flags(flag_q)
  );

  kwu_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_sync(sync_q), .flags(flag_q), .dout(dout), .dir(dir_q),
    .pol(pol_q), .ien(ien_q), .pull_on(pull_on), .clr(clr)
  );

  assign pad_out     = dout;
  assign pad_oe      = dir_q;
  assign pad_pull_en = {W{pull_on}} & ~dir_q;
  assign pad_pull_up = ~pol_q;
  assign irq         = |(flag_q & ien_q);
  assign wake        = |(evt & ien_q);
endmodule

// File: rtl/kwu_port_chk.sv
module kwu_port_chk
  import kwu_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_pull_en,
  input logic              wake,
  input logic              irq,
  input logic [W-1:0]      flag_q,
  input logic [W-1:0]      sync_q,
  input logic [W-1:0]      prev_q
);
  AST_PULL_ONLY_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0);  // R8

  AST_WAKE_THEN_IRQ: assert property (@(posedge clk) disable iff (rst)
    wake |=> irq);  // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_we && bus_addr == REG_FLAG)
      |=> ((flag_q & $past(flag_q)) == $past(flag_q)));  // R6

  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((sync_q ^ prev_q) == '0) |=> ((flag_q & ~$past(flag_q)) == '0));  // R3

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ((sync_q ^ prev_q) == '0) |-> !wake);  // R9
endmodule

bind kwu_port kwu_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
  .wake(wake), .irq(irq), .flag_q(flag_q), .sync_q(sync_q), .prev_q(prev_q)
);

// File: tb/kwu_port_test.sv
module kwu_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata, pad_in, pad_out, pad_oe, pad_pull_en, pad_pull_up;
  logic         irq, wake;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  logic [W-1:0] m_pol = '0, m_ien = '0, m_flag = '0, m_pins;

  always #10 clk = ~clk;

  kwu_port #(.W(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .irq(irq), .wake(wake)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data on each read cycle
  always @(negedge clk) begin
    if (bus_sel && !bus_we && exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_sel = 0; bus_we = 0;
    if (a == 3'd2) m_pol = d;
    if (a == 3'd3) m_ien = d;
    if (a == 3'd4) m_flag = m_flag & ~d;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [W-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    tick(1);
    bus_sel = 0;
  endtask

  task automatic set_pins(input logic [W-1:0] v, input string t);
    logic [W-1:0] ev;
    ev = (v & ~m_pins & m_pol) | (~v & m_pins & ~m_pol);
    pad_in = v;
    m_pins = v;
    tick(1);
    check({t, " R10 no early irq"}, {7'd0, irq}, {7'd0, |(m_flag & m_ien)});
    tick(1);
    check({t, " R9 wake"}, {7'd0, wake}, {7'd0, |(ev & m_ien)});
    m_flag = m_flag | ev;
    tick(1);
    check({t, " R7 irq"}, {7'd0, irq}, {7'd0, |(m_flag & m_ien)});
    check({t, " R9 wake ends"}, {7'd0, wake}, 8'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pad_in = '1; m_pins = '1;
    tick(3);
    rst = 0;
    tick(4);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pull_en", pad_pull_en, 8'h00);
    check("R1 pull_up", pad_pull_up, 8'hFF);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 wake", {7'd0, wake}, 8'd0);
    rd_expect(3'd1, 8'h00, "R1 dir");
    rd_expect(3'd2, 8'h00, "R1 pol");
    rd_expect(3'd3, 8'h00, "R1 ien");
    rd_expect(3'd4, 8'h00, "R1 flags");
    rd_expect(3'd5, 8'h00, "R1 ctrl");
    // R8 pulls
    wr(3'd5, 8'h01);
    check("R8 pull_en all inputs", pad_pull_en, 8'hFF);
    wr(3'd2, 8'h0F);
    check("R8 pull_up follows pol", pad_pull_up, 8'hF0);
    wr(3'd1, 8'h03);
    check("R8 no pull on outputs", pad_pull_en, 8'hFC);
    // R2 direction and output latch
    wr(3'd0, 8'hA5);
    check("R2 pad_out", pad_out, 8'hA5);
    check("R2 pad_oe", pad_oe, 8'h03);
    rd_expect(3'd0, 8'hFF, "R11 read returns pins not latch");
    // R4 falling on rising-trigger pins ignored
    set_pins(8'hF0, "R4 fall ignored");
    rd_expect(3'd4, 8'h00, "R4 opposite edge no flag");
    // R4/R5 rising on rising-trigger pins, bits 0-1 are outputs
    set_pins(8'hFF, "R4 rise");
    rd_expect(3'd4, 8'h0F, "R4 R5 rising flags incl outputs");
    // R3 falling on falling-trigger pins
    set_pins(8'h0F, "R3 fall");
    rd_expect(3'd4, 8'hFF, "R3 falling flags");
    // R6 sticky and write-1-to-clear
    wr(3'd4, 8'h00);
    rd_expect(3'd4, 8'hFF, "R6 write zero keeps flags");
    wr(3'd4, 8'h0F);
    rd_expect(3'd4, 8'hF0, "R6 w1c clears");
    // R7 enable gating
    check("R7 disabled flags no irq", {7'd0, irq}, 8'd0);
    wr(3'd3, 8'h80);
    check("R7 enabled flag irq", {7'd0, irq}, 8'd1);
    wr(3'd4, 8'hF0);
    check("R7 cleared irq", {7'd0, irq}, 8'd0);
    // R9/R10 enabled edge
    set_pins(8'h8F, "R9 rise no event");
    set_pins(8'h0F, "R9 enabled fall");
    rd_expect(3'd4, 8'h80, "R9 flag after wake");
    // R6 set wins over simultaneous clear
    wr(3'd4, 8'h80);
    set_pins(8'h8F, "R6 prep");
    pad_in = 8'h0F; m_pins = 8'h0F;
    tick(2);
    check("R9 wake before clear collision", {7'd0, wake}, 8'd1);
    wr(3'd4, 8'h80);
    m_flag = 8'h80;
    rd_expect(3'd4, 8'h80, "R6 set wins over clear");
    check("R6 irq stays", {7'd0, irq}, 8'd1);
    // R11 synchronized read
    set_pins(8'h5A, "R11 pins");
    rd_expect(3'd0, 8'h5A, "R11 data read");
    check("R2 latch unchanged", pad_out, 8'hA5);
    tick(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule